// File: doc/BRIEF.md
# Vector-Driven Pin Channel for Digital In-Circuit Testing

This block sits between a stream of test vectors and a group of tester pins on a device under test. Each vector carries one 3-bit symbol per pin. A pin marked as driven by the tester turns its symbol into an output level and an output enable. The new levels take effect on the clock edge that accepts the vector. A pin marked as received turns its symbol into an expected level and a compare mask. At a programmable strobe tick inside the vector period, the received pins are sampled against those expectations. Each vector then reports a pass/fail result with its mismatch mask and its position in the unit.

Vectors run in units. A start pulse latches the timing and pin configuration, clears the sticky failure record and begins fetching. The vector tagged as last ends the unit when its period expires, and every pin is released at that point. One pin can be named as a disable control. For the whole unit it is driven to a fixed level, whatever the vectors say, so that an upstream bus driver stays in high impedance. It is never compared.

The sequencer has four states. `ST_IDLE` waits for a start. `ST_CFG_ERR` holds after a start whose strobe tick is not below the period. `ST_FETCH` waits for a vector. `ST_RUN` counts the vector period. The transitions are:
- `ST_IDLE`/`ST_CFG_ERR` to `ST_FETCH` on a start with good timing.
- `ST_IDLE`/`ST_CFG_ERR` to `ST_CFG_ERR` on a start with bad timing.
- `ST_FETCH` to `ST_RUN` on an accepted vector.
- `ST_RUN` to `ST_RUN` when the next vector is accepted at the final tick.
- `ST_RUN` to `ST_FETCH` at the final tick when no vector is offered.
- `ST_RUN` to `ST_IDLE` at the final tick of the last vector.

Top module: `tvc_pin_channel`

## Requirements
- R1: After reset, every output enable is 0 and `vec_ready`, `unit_busy`, `cfg_err`, `res_valid` and `fail_flag` are all 0.
- R2: On a driven pin (its `cfg_drive_mask` bit is 1), symbol 0 drives low with enable, symbol 1 drives high with enable, and symbol 4 (high-Z) clears the enable and keeps the level. Each change is seen right after the edge that accepts the vector.
- R3: On a driven pin, symbol 2 (keep) leaves level and enable unchanged. Symbol 3 (toggle) inverts the previous level and sets the enable. Symbols 5, 6 and 7 (don't-care) leave the pin unchanged.
- R4: A received pin (mask bit 0) never has its enable set. Symbols 0 and 1 expect that level. Symbol 2 expects the previous expectation again. Symbol 3 expects its inverse.
- R5: On a received pin, symbols 4, 5, 6 and 7 mask the pin out of the comparison.
- R6: The period is the latched `cfg_cycle_len` in clocks. `vec_ready` is high in `ST_FETCH` and at the final tick of a non-last vector. With a continuous stream, vectors are accepted exactly `cfg_cycle_len` clocks apart. Without one, the block stalls in `ST_FETCH`.
- R7: The pins are sampled at the edge `cfg_strobe_dly`+1 clocks after acceptance. The result (`res_valid` pulse, pass, mismatch mask, index from 0 in the unit) appears right after that edge. This holds even when the edge coincides with the acceptance of the next vector.
- R8: A start with `cfg_strobe_dly` >= `cfg_cycle_len` enters `ST_CFG_ERR`, raises `cfg_err` and accepts no vector until a start with good timing.
- R9: With `cfg_dis_en` set, the pin numbered `cfg_dis_sel` is driven at `cfg_dis_level` with enable for the whole unit. Its symbols are overridden and it never takes part in the comparison.
- R10: `fail_flag` sets on the first failing vector of a unit, and `first_fail_index` then holds that vector's index. Both stay until the next accepted start clears them.
- R11: A start pulse while a unit is running is ignored. Configuration inputs are latched at the start. After the last vector's period, the block returns to `ST_IDLE` with every enable cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cycle_len | input | CW | Vector period in clocks |
| cfg_strobe_dly | input | CW | Strobe tick within the period |
| cfg_drive_mask | input | NPINS | 1 = tester drives the pin, 0 = tester receives |
| cfg_dis_en | input | 1 | Enables the disable-control pin |
| cfg_dis_sel | input | SW | Number of the disable-control pin |
| cfg_dis_level | input | 1 | Level held on the disable-control pin |
| unit_start | input | 1 | Starts a unit |
| vec_valid | input | 1 | Vector offered |
| vec_ready | output | 1 | Vector can be accepted |
| vec_last | input | 1 | Offered vector ends the unit |
| vec_codes | input | 3*NPINS | Symbol per pin, pin i at bits 3i+2..3i |
| pin_in | input | NPINS | Sampled pin levels |
| pin_out | output | NPINS | Drive levels |
| pin_oe | output | NPINS | Drive enables |
| unit_busy | output | 1 | In `ST_FETCH` or `ST_RUN` |
| cfg_err | output | 1 | In `ST_CFG_ERR` |
| res_valid | output | 1 | One-cycle result pulse |
| res_pass | output | 1 | Last result passed |
| res_index | output | IW | Index of the reported vector |
| res_mismatch | output | NPINS | Failing pins of the last result |
| fail_flag | output | 1 | Sticky failure of the unit |
| first_fail_index | output | IW | Index of the first failing vector |

## Verification
The strobe of one vector and the acceptance of the next fall on the same clock edge when the strobe tick is one below the period. The bench sets up this case with a period of 3 and a strobe of 2, and again with a period of 1 and a strobe of 0, streaming vectors back to back. It then judges that the result still carries the old vector's index and expectations while the pins already show the new drive. The end of a unit can also meet an ignored start pulse. A reference model that runs on every clock compares all outputs across both cases.

// File: rtl/tvc_pkg.sv
package tvc_pkg;

    localparam logic [2:0] SYM_LO     = 3'd0;
    localparam logic [2:0] SYM_HI     = 3'd1;
    localparam logic [2:0] SYM_KEEP   = 3'd2;
    localparam logic [2:0] SYM_TOGGLE = 3'd3;
    localparam logic [2:0] SYM_HIZ    = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CFG_ERR = 2'd1,
        ST_FETCH   = 2'd2,
        ST_RUN     = 2'd3
    } seq_state_e;

endpackage

// File: rtl/tvc_pin_slice.sv
module tvc_pin_slice
    import tvc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       clear,
    input  logic       load,
    input  logic       finish,
    input  logic       is_drv,
    input  logic       is_dis,
    input  logic       dis_lvl,
    input  logic [2:0] code,
    output logic       drv_out,
    output logic       drv_oe,
    output logic       exp_lvl,
    output logic       exp_care
);

    logic out_q, oe_q, exp_q, care_q;
    logic out_d, oe_d, exp_d, care_d;

    always_comb begin
        out_d  = out_q;
        oe_d   = oe_q;
        exp_d  = exp_q;
        care_d = care_q;
        if (clear) begin
            out_d  = is_dis & dis_lvl;
            oe_d   = is_dis;
            exp_d  = 1'b0;
            care_d = 1'b0;
        end else if (finish) begin
            oe_d = 1'b0;
        end else if (load) begin
            if (is_dis) begin
                out_d  = dis_lvl;
                oe_d   = 1'b1;
                care_d = 1'b0;
            end else if (is_drv) begin
                care_d = 1'b0;
                unique case (code)
                    SYM_LO:     begin out_d = 1'b0;   oe_d = 1'b1; end
                    SYM_HI:     begin out_d = 1'b1;   oe_d = 1'b1; end
                    SYM_KEEP:   ;
                    SYM_TOGGLE: begin out_d = ~out_q; oe_d = 1'b1; end
                    SYM_HIZ:    oe_d = 1'b0;
                    default:    ;
                endcase
            end else begin
                oe_d = 1'b0;
                unique case (code)
                    SYM_LO:     begin exp_d = 1'b0;   care_d = 1'b1; end
                    SYM_HI:     begin exp_d = 1'b1;   care_d = 1'b1; end
                    SYM_KEEP:   care_d = 1'b1;
                    SYM_TOGGLE: begin exp_d = ~exp_q; care_d = 1'b1; end
                    default:    care_d = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= 1'b0;
            oe_q   <= 1'b0;
            exp_q  <= 1'b0;
            care_q <= 1'b0;
        end else begin
            out_q  <= out_d;
            oe_q   <= oe_d;
            exp_q  <= exp_d;
            care_q <= care_d;
        end
    end

    assign drv_out  = out_q;
    assign drv_oe   = oe_q;
    assign exp_lvl  = exp_q;
    assign exp_care = care_q;

    // R4: a receive pin that is not the disable control is never enabled
    p_rx_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_drv && !is_dis) |-> !oe_q);

    // R9: the disable control pin holds its level for the whole unit
    p_dis_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && is_dis) |-> (oe_q && (out_q == dis_lvl) && !care_q));

endmodule

// File: rtl/tvc_seq.sv
module tvc_seq
    import tvc_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int CW    = 16,
    parameter int IW    = 16,
    parameter int SW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    cfg_cycle_len,
    input  logic [CW-1:0]    cfg_strobe_dly,
    input  logic [NPINS-1:0] cfg_drive_mask,
    input  logic             cfg_dis_en,
    input  logic [SW-1:0]    cfg_dis_sel,
    input  logic             cfg_dis_level,
    input  logic             unit_start,
    input  logic             vec_valid,
    input  logic             vec_last,
    output logic             vec_ready,
    output logic             busy,
    output logic             cfg_err,
    output logic             clear,
    output logic             load,
    output logic             finish,
    output logic             strobe,
    output logic [IW-1:0]    cur_idx,
    output logic [NPINS-1:0] drv_mask,
    output logic [NPINS-1:0] dis_mask,
    output logic             dis_lvl
);

    seq_state_e state_q, state_d;

    logic [CW-1:0]    cnt_q, len_q, dly_q;
    logic [NPINS-1:0] drv_q, dis_q, dis_live;
    logic             lvl_q, last_q;
    logic [IW-1:0]    vcnt_q, cur_q;
    logic             start_ok, cfg_bad, at_end;

    for (genvar g = 0; g < NPINS; g++) begin : g_dis
        assign dis_live[g] = cfg_dis_en && (cfg_dis_sel == SW'(g));
    end

    assign cfg_bad  = (cfg_strobe_dly >= cfg_cycle_len);
    assign start_ok = unit_start && (state_q == ST_IDLE || state_q == ST_CFG_ERR);
    assign at_end   = (state_q == ST_RUN) && (cnt_q == len_q - CW'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_CFG_ERR:
                if (unit_start) state_d = cfg_bad ? ST_CFG_ERR : ST_FETCH;
            ST_FETCH:
                if (vec_valid) state_d = ST_RUN;
            ST_RUN:
                if (at_end) begin
                    if (last_q)         state_d = ST_IDLE;
                    else if (vec_valid) state_d = ST_RUN;
                    else                state_d = ST_FETCH;
                end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        vec_ready = 1'b0;
        busy      = 1'b0;
        cfg_err   = 1'b0;
        strobe    = 1'b0;
        finish    = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_CFG_ERR: cfg_err = 1'b1;
            ST_FETCH: begin
                busy      = 1'b1;
                vec_ready = 1'b1;
            end
            ST_RUN: begin
                busy      = 1'b1;
                vec_ready = at_end && !last_q;
                finish    = at_end && last_q;
                strobe    = (cnt_q == dly_q);
            end
            default: ;
        endcase
        load  = vec_ready && vec_valid;
        clear = start_ok && !cfg_bad;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            len_q  <= '0;
            dly_q  <= '0;
            drv_q  <= '0;
            dis_q  <= '0;
            lvl_q  <= 1'b0;
            last_q <= 1'b0;
            vcnt_q <= '0;
            cur_q  <= '0;
        end else if (start_ok) begin
            len_q  <= cfg_cycle_len;
            dly_q  <= cfg_strobe_dly;
            drv_q  <= cfg_drive_mask;
            dis_q  <= dis_live;
            lvl_q  <= cfg_dis_level;
            vcnt_q <= '0;
            cur_q  <= '0;
        end else if (load) begin
            cur_q  <= vcnt_q;
            vcnt_q <= vcnt_q + IW'(1);
            last_q <= vec_last;
            cnt_q  <= '0;
        end else if (state_q == ST_RUN && !at_end) begin
            cnt_q  <= cnt_q + CW'(1);
        end
    end

    assign cur_idx  = cur_q;
    assign drv_mask = drv_q;
    assign dis_mask = clear ? dis_live : dis_q;
    assign dis_lvl  = clear ? cfg_dis_level : lvl_q;

    p_err_blocks_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!vec_ready && !busy));

    p_cnt_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q < len_q));

    p_strobe_inside_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (dly_q < len_q));

    p_busy_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && unit_start && !finish) |=> busy);

endmodule

// File: rtl/tvc_check.sv
module tvc_check #(
    parameter int NPINS = 8,
    parameter int IW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             strobe,
    input  logic [IW-1:0]    cur_idx,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] exp_lvl,
    input  logic [NPINS-1:0] exp_care,
    output logic             res_valid,
    output logic             res_pass,
    output logic [IW-1:0]    res_index,
    output logic [NPINS-1:0] res_mismatch,
    output logic             fail_flag,
    output logic [IW-1:0]    first_fail_index
);

    logic [NPINS-1:0] mism;
    assign mism = (pin_in ^ exp_lvl) & exp_care;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid        <= 1'b0;
            res_pass         <= 1'b0;
            res_index        <= '0;
            res_mismatch     <= '0;
            fail_flag        <= 1'b0;
            first_fail_index <= '0;
        end else begin
            res_valid <= strobe;
            if (strobe) begin
                res_pass     <= (mism == '0);
                res_index    <= cur_idx;
                res_mismatch <= mism;
            end
            if (clear) begin
                fail_flag        <= 1'b0;
                first_fail_index <= '0;
            end else if (strobe && (mism != '0) && !fail_flag) begin
                fail_flag        <= 1'b1;
                first_fail_index <= cur_idx;
            end
        end
    end

    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_flag && !clear) |=> (fail_flag && (first_fail_index == $past(first_fail_index))));

    p_result_follows_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> res_valid);

    p_pass_means_no_mism_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_pass == (res_mismatch == '0)));

endmodule

// File: rtl/tvc_pin_channel.sv
module tvc_pin_channel
    import tvc_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int CW    = 16,
    parameter int IW    = 16,
    localparam int SW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CW-1:0]      cfg_cycle_len,
    input  logic [CW-1:0]      cfg_strobe_dly,
    input  logic [NPINS-1:0]   cfg_drive_mask,
    input  logic               cfg_dis_en,
    input  logic [SW-1:0]      cfg_dis_sel,
    input  logic               cfg_dis_level,
    input  logic               unit_start,
    input  logic               vec_valid,
    output logic               vec_ready,
    input  logic               vec_last,
    input  logic [3*NPINS-1:0] vec_codes,
    input  logic [NPINS-1:0]   pin_in,
    output logic [NPINS-1:0]   pin_out,
    output logic [NPINS-1:0]   pin_oe,
    output logic               unit_busy,
    output logic               cfg_err,
    output logic               res_valid,
    output logic               res_pass,
    output logic [IW-1:0]      res_index,
    output logic [NPINS-1:0]   res_mismatch,
    output logic               fail_flag,
    output logic [IW-1:0]      first_fail_index
);

    logic             clear, load, finish, strobe, dis_lvl;
    logic [IW-1:0]    cur_idx;
    logic [NPINS-1:0] drv_mask, dis_mask, exp_lvl, exp_care;

    tvc_seq #(.NPINS(NPINS), .CW(CW), .IW(IW), .SW(SW)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_cycle_len  (cfg_cycle_len),
        .cfg_strobe_dly (cfg_strobe_dly),
        .cfg_drive_mask (cfg_drive_mask),
        .cfg_dis_en     (cfg_dis_en),
        .cfg_dis_sel    (cfg_dis_sel),
        .cfg_dis_level  (cfg_dis_level),
        .unit_start     (unit_start),
        .vec_valid      (vec_valid),
        .vec_last       (vec_last),
        .vec_ready      (vec_ready),
        .busy           (unit_busy),
        .cfg_err        (cfg_err),
        .clear          (clear),
        .load           (load),
        .finish         (finish),
        .strobe         (strobe),
        .cur_idx        (cur_idx),
        .drv_mask       (drv_mask),
        .dis_mask       (dis_mask),
        .dis_lvl        (dis_lvl)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        tvc_pin_slice u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .active   (unit_busy),
            .clear    (clear),
            .load     (load),
            .finish   (finish),
            .is_drv   (drv_mask[p]),
            .is_dis   (dis_mask[p]),
            .dis_lvl  (dis_lvl),
            .code     (vec_codes[3*p +: 3]),
            .drv_out  (pin_out[p]),
            .drv_oe   (pin_oe[p]),
            .exp_lvl  (exp_lvl[p]),
            .exp_care (exp_care[p])
        );
    end

    tvc_check #(.NPINS(NPINS), .IW(IW)) u_check (
        .clk              (clk),
        .rst_n            (rst_n),
        .clear            (clear),
        .strobe           (strobe),
        .cur_idx          (cur_idx),
        .pin_in           (pin_in),
        .exp_lvl          (exp_lvl),
        .exp_care         (exp_care),
        .res_valid        (res_valid),
        .res_pass         (res_pass),
        .res_index        (res_index),
        .res_mismatch     (res_mismatch),
        .fail_flag        (fail_flag),
        .first_fail_index (first_fail_index)
    );

    p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!unit_busy && !$past(unit_start)) |-> (pin_oe == '0));

endmodule

// File: tb/sim_tvc_pin_channel.sv
`timescale 1ns/1ps
module sim_tvc_pin_channel;

    localparam int NP = 8;
    localparam int CW = 16;
    localparam int IW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] cfg_cycle_len = 16'd4, cfg_strobe_dly = 16'd2;
    logic [NP-1:0] cfg_drive_mask = 8'h0F;
    logic cfg_dis_en = 1'b0, cfg_dis_level = 1'b0;
    logic [2:0] cfg_dis_sel = 3'd0;
    logic unit_start = 1'b0, vec_valid = 1'b0, vec_last = 1'b0;
    logic [3*NP-1:0] vec_codes = '0;
    logic [NP-1:0] pin_in = '0;
    logic vec_ready, unit_busy, cfg_err, res_valid, res_pass, fail_flag;
    logic [NP-1:0] pin_out, pin_oe, res_mismatch;
    logic [IW-1:0] res_index, first_fail_index;

    always #2 clk = ~clk;

    tvc_pin_channel #(.NPINS(NP), .CW(CW), .IW(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cycle_len(cfg_cycle_len),
        .cfg_strobe_dly(cfg_strobe_dly), .cfg_drive_mask(cfg_drive_mask),
        .cfg_dis_en(cfg_dis_en), .cfg_dis_sel(cfg_dis_sel),
        .cfg_dis_level(cfg_dis_level), .unit_start(unit_start),
        .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_last(vec_last),
        .vec_codes(vec_codes), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .unit_busy(unit_busy), .cfg_err(cfg_err),
        .res_valid(res_valid), .res_pass(res_pass), .res_index(res_index),
        .res_mismatch(res_mismatch), .fail_flag(fail_flag),
        .first_fail_index(first_fail_index)
    );

    int checks = 0, fails = 0;
    string tag = "R1";
    bit chk_en = 1'b0, done = 1'b0;

    // behavioural reference: mode 0 idle, 1 config error, 2 waiting, 3 running
    int m_md = 0, m_cnt = 0, m_len = 0, m_dly = 0, m_vidx = 0, m_cur = 0, m_fi = 0;
    bit m_last = 0, m_lvl = 0, m_rv = 0, m_rp = 0, m_ff = 0;
    logic [NP-1:0] m_drv = '0, m_dis = '0, m_out = '0, m_oe = '0, m_exp = '0, m_care = '0, m_rm = '0;
    int m_ri = 0;

    function automatic logic [2:0] sym(int i);
        return vec_codes[3*i +: 3];
    endfunction

    always @(posedge clk) begin
        logic [NP-1:0] mm;
        bit rdy, stb, endu;
        if (!rst_n) begin
            m_md = 0; m_cnt = 0; m_len = 0; m_dly = 0; m_vidx = 0; m_cur = 0; m_fi = 0;
            m_last = 0; m_lvl = 0; m_rv = 0; m_rp = 0; m_ff = 0; m_ri = 0;
            m_drv = '0; m_dis = '0; m_out = '0; m_oe = '0; m_exp = '0; m_care = '0; m_rm = '0;
        end else begin
            m_rv = 0;
            stb  = (m_md == 3) && (m_cnt == m_dly);
            if (stb) begin
                mm = (pin_in ^ m_exp) & m_care;
                m_rv = 1; m_rp = (mm == '0); m_ri = m_cur; m_rm = mm;
                if (mm != '0 && !m_ff) begin m_ff = 1; m_fi = m_cur; end
            end
            rdy  = (m_md == 2) || (m_md == 3 && m_cnt == m_len - 1 && !m_last);
            endu = (m_md == 3) && (m_cnt == m_len - 1) && m_last;
            if (unit_start && m_md < 2) begin
                m_len = int'(cfg_cycle_len); m_dly = int'(cfg_strobe_dly);
                m_drv = cfg_drive_mask; m_lvl = cfg_dis_level;
                for (int i = 0; i < NP; i++) m_dis[i] = cfg_dis_en && (int'(cfg_dis_sel) == i);
                m_vidx = 0; m_cur = 0; m_ff = 0; m_fi = 0;
                if (m_dly >= m_len) m_md = 1;
                else begin
                    m_md = 2;
                    for (int i = 0; i < NP; i++) begin
                        m_out[i] = m_dis[i] & m_lvl; m_oe[i] = m_dis[i];
                        m_exp[i] = 0; m_care[i] = 0;
                    end
                end
            end else if (rdy && vec_valid) begin
                for (int i = 0; i < NP; i++) begin
                    if (m_dis[i]) begin m_out[i] = m_lvl; m_oe[i] = 1; m_care[i] = 0; end
                    else if (m_drv[i]) begin
                        m_care[i] = 0;
                        if (sym(i) == 0) begin m_out[i] = 0; m_oe[i] = 1; end
                        else if (sym(i) == 1) begin m_out[i] = 1; m_oe[i] = 1; end
                        else if (sym(i) == 3) begin m_out[i] = ~m_out[i]; m_oe[i] = 1; end
                        else if (sym(i) == 4) m_oe[i] = 0;
                    end else begin
                        m_oe[i] = 0;
                        if (sym(i) == 0) begin m_exp[i] = 0; m_care[i] = 1; end
                        else if (sym(i) == 1) begin m_exp[i] = 1; m_care[i] = 1; end
                        else if (sym(i) == 2) m_care[i] = 1;
                        else if (sym(i) == 3) begin m_exp[i] = ~m_exp[i]; m_care[i] = 1; end
                        else m_care[i] = 0;
                    end
                end
                m_cur = m_vidx; m_vidx++; m_last = vec_last; m_cnt = 0; m_md = 3;
            end else if (endu) begin
                m_oe = '0; m_md = 0;
            end else if (m_md == 3) begin
                if (m_cnt == m_len - 1) m_md = 2;
                else m_cnt++;
            end
        end
    end

    task automatic cmp(string sig, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%0h exp=%0h at %0t", tag, sig, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && !done) begin
            cmp("pin_oe", 32'(pin_oe), 32'(m_oe));
            cmp("pin_out", 32'(pin_out), 32'(m_out));
            cmp("vec_ready", 32'(vec_ready),
                32'((m_md == 2) || (m_md == 3 && m_cnt == m_len - 1 && !m_last)));
            cmp("unit_busy", 32'(unit_busy), 32'(m_md >= 2));
            cmp("cfg_err", 32'(cfg_err), 32'(m_md == 1));
            cmp("res_valid", 32'(res_valid), 32'(m_rv));
            cmp("res_pass", 32'(res_pass), 32'(m_rp));
            cmp("res_index", 32'(res_index), 32'(m_ri));
            cmp("res_mismatch", 32'(res_mismatch), 32'(m_rm));
            cmp("fail_flag", 32'(fail_flag), 32'(m_ff));
            cmp("first_fail_index", 32'(first_fail_index), 32'(m_fi));
        end
    end

    function automatic logic [23:0] pk(logic [2:0] c0, logic [2:0] c1, logic [2:0] c2, logic [2:0] c3,
                                       logic [2:0] c4, logic [2:0] c5, logic [2:0] c6, logic [2:0] c7);
        return {c7, c6, c5, c4, c3, c2, c1, c0};
    endfunction

    task automatic start_unit(int len, int dly);
        @(negedge clk);
        cfg_cycle_len = 16'(len); cfg_strobe_dly = 16'(dly);
        unit_start = 1'b1;
        @(negedge clk);
        unit_start = 1'b0;
    endtask

    task automatic send(logic [23:0] c, bit last, logic [NP-1:0] pins);
        vec_valid = 1'b1; vec_codes = c; vec_last = last;
        while (!vec_ready) @(negedge clk);
        @(negedge clk);
        vec_valid = 1'b0; vec_last = 1'b0;
        pin_in = pins;
    endtask

    task automatic finish_unit();
        while (unit_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL R6 watchdog expired got=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        tag = "R1";
        @(posedge clk); @(negedge clk);
        chk_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8: strobe not inside the period
        tag = "R8";
        start_unit(4, 4);
        vec_valid = 1'b1; vec_codes = pk(1,1,1,1,1,1,1,1);
        repeat (5) @(negedge clk);
        vec_valid = 1'b0;

        // R2/R4: plain drive and receive levels, pins 0..3 driven
        tag = "R2";
        cfg_drive_mask = 8'h0F;
        start_unit(4, 2);
        send(pk(0,1,0,1, 0,1,0,1), 0, 8'b1010_0000);
        // R3 and R4: keep/toggle/high-Z/don't-care
        tag = "R3";
        send(pk(2,3,4,5, 2,3,2,3), 0, 8'b0110_0000);
        // R5: masked receive codes, arbitrary pins
        tag = "R5";
        send(pk(6,7,3,3, 4,5,6,7), 0, 8'b1101_0000);
        // R4: mismatch on pin 5
        tag = "R4";
        send(pk(4,4,1,0, 1,1,0,0), 1, 8'b0001_0000);
        finish_unit();

        // R6: stall between vectors
        tag = "R6";
        start_unit(6, 1);
        send(pk(1,0,1,0, 1,0,1,0), 0, 8'b0101_0000);
        repeat (9) @(negedge clk);
        send(pk(3,3,3,3, 3,3,3,3), 1, 8'b1010_0000);
        finish_unit();

        // R7: strobe on the same edge as the next acceptance
        tag = "R7";
        start_unit(3, 2);
        send(pk(0,0,0,0, 0,0,0,0), 0, 8'b0000_0000);
        send(pk(1,1,1,1, 1,1,1,1), 0, 8'b1111_0000);
        send(pk(3,3,3,3, 3,3,3,3), 0, 8'b0100_0000);
        send(pk(0,1,0,1, 2,2,2,2), 1, 8'b0000_0000);
        finish_unit();
        start_unit(1, 0);
        send(pk(1,0,1,0, 1,1,1,1), 0, 8'b1111_0000);
        send(pk(3,3,3,3, 3,3,3,3), 0, 8'b0000_0000);
        send(pk(3,3,3,3, 0,0,0,0), 1, 8'b0001_0000);
        finish_unit();

        // R9: disable control on a driven pin, then on a receive pin
        tag = "R9";
        cfg_dis_en = 1'b1; cfg_dis_sel = 3'd2; cfg_dis_level = 1'b0;
        start_unit(3, 1);
        send(pk(1,1,1,1, 1,1,1,1), 0, 8'b1111_0000);
        send(pk(3,3,3,3, 0,0,0,0), 1, 8'b0000_0000);
        finish_unit();
        cfg_dis_sel = 3'd5; cfg_dis_level = 1'b1;
        start_unit(3, 1);
        send(pk(0,0,0,0, 0,0,0,0), 0, 8'b0000_0000);
        send(pk(1,1,1,1, 1,1,1,1), 1, 8'b1101_0000);
        finish_unit();
        cfg_dis_en = 1'b0;

        // R10: sticky failure, first index kept, cleared by next start
        tag = "R10";
        start_unit(4, 3);
        send(pk(0,0,0,0, 0,0,0,0), 0, 8'b0000_0000);
        send(pk(0,0,0,0, 1,1,1,1), 0, 8'b0111_0000);
        send(pk(0,0,0,0, 0,0,0,0), 0, 8'b1000_0000);
        send(pk(0,0,0,0, 5,5,5,5), 1, 8'b0000_0000);
        finish_unit();
        start_unit(4, 3);
        send(pk(1,1,1,1, 0,0,0,0), 1, 8'b0000_0000);
        finish_unit();

        // R11: start while busy is ignored, configuration latched
        tag = "R11";
        start_unit(4, 2);
        fork
            begin
                send(pk(1,0,1,0, 0,1,0,1), 0, 8'b1010_0000);
                send(pk(3,3,3,3, 3,3,3,3), 0, 8'b0101_0000);
                send(pk(4,4,4,4, 2,2,2,2), 1, 8'b0101_0000);
            end
            begin
                repeat (3) @(negedge clk);
                cfg_cycle_len = 16'd9; cfg_drive_mask = 8'hF0;
                unit_start = 1'b1;
                @(negedge clk);
                unit_start = 1'b0;
            end
        join
        finish_unit();
        cfg_drive_mask = 8'h0F;
        repeat (4) @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule